// File: doc/BRIEF.md
# Carrier Tracking Loop Filter with Frequency-Loop Assist

This block is the digital loop filter of a receiver's carrier tracking loop. Once per update interval it takes a signed frequency-discriminator error and a signed phase-discriminator error and returns a signed frequency command for an external oscillator. The oscillator performs the final integration to carrier phase, so the filter ends with a frequency value and not a phase value. Each error has an enable. With the phase enable low the filter acts as a pure frequency-locked loop. With the frequency enable low it acts as a pure phase-locked loop. With both enables high it acts as a phase loop helped by a frequency loop.

A compile-time parameter selects the structure. The order-2 variant is a second-order phase loop with first-order frequency assist and uses one internal accumulator (velocity). The order-3 variant is a third-order phase loop with second-order frequency assist and uses two accumulators (acceleration feeding velocity). Every internal integrator is trapezoidal: it adds its input to its state and passes on half the sum of the new and old state. The frequency error enters one integrator earlier than the matching phase term. All gains are runtime inputs in signed fixed point with GAIN_FRAC fraction bits, and the update interval is already folded into them. In the order-3 variant the acceleration-path gains carry the interval squared.

An update starts on a one-cycle `validIn` strobe. The new command appears with `validOut` one cycle later. `clear` zeroes all filter state so that the loop can be restarted or its mode changed without a transient.

Top module: `carrier_loop_filter`

## Requirements
- R1: After reset, and in the cycle after `clear` is high, `freqCmd` is 0 and `validOut` is 0. Every accumulator also restarts from zero, so the next update gives the same result as the first update after reset.
- R2: `validOut` is 1 exactly in the cycle after a cycle in which `validIn` is 1 and `clear` is 0. `freqCmd` does not change in a cycle that follows one with neither `validIn` nor `clear`.
- R3: Order 2, with scl(e,g) = floor(e*g / 2^GAIN_FRAC). On each update, vNew = sat(v + scl(pe,gPhaseAcc) + scl(fe,gFreqAcc)) and freqCmd = sat(floor((vNew+v)/2) + scl(pe,gPhaseProp)). The inputs gFreqVel and gPhaseVel have no effect.
- R4: Order 3. On each update, aNew = sat(a + scl(pe,gPhaseAcc) + scl(fe,gFreqAcc)) and vNew = sat(v + floor((aNew+a)/2) + scl(pe,gPhaseVel) + scl(fe,gFreqVel)). The output is freqCmd = sat(floor((vNew+v)/2) + scl(pe,gPhaseProp)).
- R5: With `freqEn` = 0 the value on `freqErr` is treated as zero, which gives a pure phase loop.
- R6: With `phaseEn` = 0 the value on `phaseErr` is treated as zero, which gives a pure frequency loop. A constant frequency error then makes the order-2 command ramp by scl(fe,gFreqAcc) per update.
- R7: sat() clamps to the signed ACC_W range, from -2^(ACC_W-1) to 2^(ACC_W-1)-1. Accumulators and the command stop at these limits and never wrap.
- R8: A trapezoidal stage passes on floor((new+old)/2), rounding toward minus infinity, and keeps its full new sum as state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all filter state; has priority over validIn |
| validIn | input | 1 | One-cycle update strobe |
| freqErr | input | ERR_W | Signed frequency-discriminator error |
| freqEn | input | 1 | 1 = use freqErr, 0 = treat it as zero |
| phaseErr | input | ERR_W | Signed phase-discriminator error |
| phaseEn | input | 1 | 1 = use phaseErr, 0 = treat it as zero |
| gFreqAcc | input | GAIN_W | Frequency gain into the first accumulator |
| gPhaseAcc | input | GAIN_W | Phase gain into the first accumulator |
| gFreqVel | input | GAIN_W | Frequency gain into velocity (order 3 only) |
| gPhaseVel | input | GAIN_W | Phase gain into velocity (order 3 only) |
| gPhaseProp | input | GAIN_W | Proportional phase gain at the output |
| freqCmd | output | ACC_W | Signed frequency command |
| validOut | output | 1 | High for one cycle when freqCmd is updated |

## Verification
Both orders run side by side against an integer model. A constant frequency error with the phase gated off shows the accumulator ramp of a pure frequency loop. A phase error with a large frequency value on a disabled input shows that the gating removes the frequency path. A sweep of signed error pairs over all four enable combinations separates sign handling, floor rounding and the two insertion points. Long runs of a large error in each direction push the narrow order-2 instance into both saturation limits, and a mid-run clear shows that no state survives a restart.

// File: rtl/clf_pkg.sv
package clf_pkg;

  typedef struct packed {
    logic step;
    logic flush;
  } clf_strobe_t;

  localparam int NTERM    = 5;
  localparam int T_FACC   = 0;
  localparam int T_PACC   = 1;
  localparam int T_PPROP  = 2;
  localparam int T_FVEL   = 3;
  localparam int T_PVEL   = 4;

  function automatic bit isFreqTerm(input int idx);
    return (idx == T_FACC) || (idx == T_FVEL);
  endfunction

  function automatic logic signed [63:0] satTo(input logic signed [63:0] v, input int w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/clf_term.sv
module clf_term #(
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int SUM_W     = 34
) (
  input  logic signed [ERR_W-1:0]  err,
  input  logic                     en,
  input  logic signed [GAIN_W-1:0] gain,
  output logic signed [SUM_W-1:0]  term
);
  localparam int PROD_W = ERR_W + GAIN_W;

  logic signed [ERR_W-1:0]  gated;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  always_comb begin
    gated  = en ? err : '0;
    prod   = PROD_W'(gated) * PROD_W'(gain);
    scaled = prod >>> GAIN_FRAC;
    term   = SUM_W'(scaled);
  end
endmodule

// File: rtl/clf_bilin.sv
module clf_bilin
  import clf_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int SUM_W = ACC_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  clf_strobe_t             stb,
  input  logic signed [SUM_W-1:0] inVal,
  output logic signed [ACC_W-1:0] halfSum
);
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] accNew;

  always_comb begin
    accNew  = ACC_W'(satTo(64'(acc) + 64'(inVal), ACC_W));
    halfSum = ACC_W'((64'(accNew) + 64'(acc)) >>> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          acc <= '0;
    else if (stb.flush) acc <= '0;
    else if (stb.step)  acc <= accNew;
  end
endmodule

// File: rtl/clf_ctrl.sv
module clf_ctrl
  import clf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        validIn,
  output clf_strobe_t stb,
  output logic        validOut
);
  always_comb begin
    stb.flush = clear;
    stb.step  = validIn & ~clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= stb.step;
  end
endmodule

// File: rtl/clf_datapath.sv
module clf_datapath
  import clf_pkg::*;
#(
  parameter int PLL_ORDER = 3,
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int ACC_W     = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  clf_strobe_t              stb,
  input  logic signed [ERR_W-1:0]  freqErr,
  input  logic                     freqEn,
  input  logic signed [ERR_W-1:0]  phaseErr,
  input  logic                     phaseEn,
  input  logic signed [GAIN_W-1:0] gains [NTERM],
  output logic signed [ACC_W-1:0]  freqCmd
);
  localparam int SUM_W = ACC_W + 2;

  logic signed [SUM_W-1:0] term [NTERM];
  logic signed [SUM_W-1:0] velIn;
  logic signed [ACC_W-1:0] velHalf;
  logic signed [ACC_W-1:0] cmdNext;

  for (genvar i = 0; i < NTERM; i++) begin : g_term
    clf_term #(
      .ERR_W(ERR_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .SUM_W(SUM_W)
    ) u_term (
      .err (isFreqTerm(i) ? freqErr : phaseErr),
      .en  (isFreqTerm(i) ? freqEn  : phaseEn),
      .gain(gains[i]),
      .term(term[i])
    );
  end

  if (PLL_ORDER == 3) begin : g_ord3
    logic signed [ACC_W-1:0] accelHalf;
    clf_bilin #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_accel (
      .clk(clk), .rstN(rstN), .stb(stb),
      .inVal(term[T_FACC] + term[T_PACC]),
      .halfSum(accelHalf)
    );
    assign velIn = SUM_W'(accelHalf) + term[T_FVEL] + term[T_PVEL];
  end else begin : g_ord2
    logic unusedVelTerms;
    assign unusedVelTerms = ^{term[T_FVEL], term[T_PVEL]};
    assign velIn = term[T_FACC] + term[T_PACC];
  end

  clf_bilin #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_vel (
    .clk(clk), .rstN(rstN), .stb(stb),
    .inVal(velIn),
    .halfSum(velHalf)
  );

  always_comb begin
    cmdNext = ACC_W'(satTo(64'(velHalf) + 64'(term[T_PPROP]), ACC_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          freqCmd <= '0;
    else if (stb.flush) freqCmd <= '0;
    else if (stb.step)  freqCmd <= cmdNext;
  end
endmodule

// File: rtl/carrier_loop_filter.sv
module carrier_loop_filter
  import clf_pkg::*;
#(
  parameter int PLL_ORDER = 3,
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 14,
  parameter int ACC_W     = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clear,
  input  logic                     validIn,
  input  logic signed [ERR_W-1:0]  freqErr,
  input  logic                     freqEn,
  input  logic signed [ERR_W-1:0]  phaseErr,
  input  logic                     phaseEn,
  input  logic signed [GAIN_W-1:0] gFreqAcc,
  input  logic signed [GAIN_W-1:0] gPhaseAcc,
  input  logic signed [GAIN_W-1:0] gFreqVel,
  input  logic signed [GAIN_W-1:0] gPhaseVel,
  input  logic signed [GAIN_W-1:0] gPhaseProp,
  output logic signed [ACC_W-1:0]  freqCmd,
  output logic                     validOut
);
  clf_strobe_t             stb;
  logic signed [GAIN_W-1:0] gains [NTERM];

  always_comb begin
    gains[T_FACC]  = gFreqAcc;
    gains[T_PACC]  = gPhaseAcc;
    gains[T_PPROP] = gPhaseProp;
    gains[T_FVEL]  = gFreqVel;
    gains[T_PVEL]  = gPhaseVel;
  end

  clf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .validIn(validIn),
    .stb(stb), .validOut(validOut)
  );

  clf_datapath #(
    .PLL_ORDER(PLL_ORDER), .ERR_W(ERR_W), .GAIN_W(GAIN_W),
    .GAIN_FRAC(GAIN_FRAC), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .freqErr(freqErr), .freqEn(freqEn),
    .phaseErr(phaseErr), .phaseEn(phaseEn),
    .gains(gains), .freqCmd(freqCmd)
  );
endmodule

// File: rtl/clf_checker.sv
module clf_checker #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             clear,
  input logic             validIn,
  input logic             freqEn,
  input logic             phaseEn,
  input logic [ACC_W-1:0] freqCmd,
  input logic             validOut
);
  p_strobe_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !clear) |=> validOut);

  p_idle_novalid_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(validIn && !clear) |=> !validOut);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!validIn && !clear) |=> $stable(freqCmd));

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (freqCmd == '0) && !validOut);

  // R5 and R6: both inputs gated right after a clear leaves the command at zero
  p_gated_rest_r6: assert property (@(posedge clk) disable iff (!rstN)
    clear ##1 (validIn && !clear && !freqEn && !phaseEn) |=> (freqCmd == '0));
endmodule

bind carrier_loop_filter clf_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .validIn(validIn),
  .freqEn(freqEn), .phaseEn(phaseEn), .freqCmd(freqCmd), .validOut(validOut)
);

// File: tb/sim_carrier_loop_filter.sv
module sim_carrier_loop_filter;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 16;
  localparam int GAIN_W = 16;
  localparam int FRAC = 14;
  localparam int A3 = 32;
  localparam int A2 = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic validIn = 1'b0;
  logic freqEn = 1'b0;
  logic phaseEn = 1'b0;
  logic signed [ERR_W-1:0] freqErr = '0;
  logic signed [ERR_W-1:0] phaseErr = '0;
  logic signed [GAIN_W-1:0] gFreqAcc = 16'sd3000;
  logic signed [GAIN_W-1:0] gPhaseAcc = 16'sd1500;
  logic signed [GAIN_W-1:0] gFreqVel = 16'sd4000;
  logic signed [GAIN_W-1:0] gPhaseVel = 16'sd2500;
  logic signed [GAIN_W-1:0] gPhaseProp = 16'sd9000;
  logic signed [A3-1:0] cmd3;
  logic signed [A2-1:0] cmd2;
  logic vo3, vo2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  carrier_loop_filter #(.PLL_ORDER(3), .ACC_W(A3)) u0 (
    .clk(clk), .rstN(rstN), .clear(clear), .validIn(validIn),
    .freqErr(freqErr), .freqEn(freqEn), .phaseErr(phaseErr), .phaseEn(phaseEn),
    .gFreqAcc(gFreqAcc), .gPhaseAcc(gPhaseAcc), .gFreqVel(gFreqVel),
    .gPhaseVel(gPhaseVel), .gPhaseProp(gPhaseProp),
    .freqCmd(cmd3), .validOut(vo3)
  );

  carrier_loop_filter #(.PLL_ORDER(2), .ACC_W(A2)) u1 (
    .clk(clk), .rstN(rstN), .clear(clear), .validIn(validIn),
    .freqErr(freqErr), .freqEn(freqEn), .phaseErr(phaseErr), .phaseEn(phaseEn),
    .gFreqAcc(gFreqAcc), .gPhaseAcc(gPhaseAcc), .gFreqVel(gFreqVel),
    .gPhaseVel(gPhaseVel), .gPhaseProp(gPhaseProp),
    .freqCmd(cmd2), .validOut(vo2)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  longint m3Acc = 0, m3Vel = 0, m2Vel = 0, exp3 = 0, exp2 = 0;

  function automatic longint satW(input longint v, input int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -hi - 1;
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  function automatic longint scl(input longint e, input longint g);
    return (e * g) >>> FRAC;
  endfunction

  task automatic chk(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic modelStep(input longint fe, input longint pe);
    longint aNew, aHalf, vNew, vHalf, v2New;
    // order 3 (R4, R8)
    aNew  = satW(m3Acc + scl(pe, gPhaseAcc) + scl(fe, gFreqAcc), A3);
    aHalf = (aNew + m3Acc) >>> 1;
    vNew  = satW(m3Vel + aHalf + scl(pe, gPhaseVel) + scl(fe, gFreqVel), A3);
    vHalf = (vNew + m3Vel) >>> 1;
    exp3  = satW(vHalf + scl(pe, gPhaseProp), A3);
    m3Acc = aNew;
    m3Vel = vNew;
    // order 2 (R3, R7)
    v2New = satW(m2Vel + scl(pe, gPhaseAcc) + scl(fe, gFreqAcc), A2);
    exp2  = satW(((v2New + m2Vel) >>> 1) + scl(pe, gPhaseProp), A2);
    m2Vel = v2New;
  endtask

  task automatic update(input int fe, input bit fen, input int pe, input bit pen, input string tag);
    @(negedge clk);
    freqErr = 16'(fe);
    freqEn = fen;
    phaseErr = 16'(pe);
    phaseEn = pen;
    validIn = 1'b1;
    modelStep(fen ? longint'(fe) : 0, pen ? longint'(pe) : 0);
    @(negedge clk);
    validIn = 1'b0;
    chk("R2 validOut after strobe", longint'(vo3), 1);
    chk({tag, " order3 R4"}, longint'(cmd3), exp3);
    chk({tag, " order2 R3"}, longint'(cmd2), exp2);
  endtask

  task automatic doClear();
    @(negedge clk);
    clear = 1'b1;
    validIn = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    validIn = 1'b0;
    chk("R1 clear order3 cmd", longint'(cmd3), 0);
    chk("R1 clear order2 cmd", longint'(cmd2), 0);
    chk("R1 clear validOut", longint'(vo3), 0);
    m3Acc = 0; m3Vel = 0; m2Vel = 0; exp3 = 0; exp2 = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", longint'(cmd3), 0);
    chk("R1 reset validOut", longint'(vo2), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset release", longint'(cmd2), 0);

    // R6 pure frequency loop: constant error, ramp in order 2
    for (int k = 0; k < 20; k++) begin
      update(2000, 1'b1, 5000, 1'b0, "R6 ramp");
      chk("R6 ramp step", m2Vel, longint'(k + 1) * scl(2000, gFreqAcc));
    end
    // R2 hold while idle
    @(negedge clk);
    chk("R2 idle validOut", longint'(vo3), 0);
    chk("R2 idle hold", longint'(cmd3), exp3);

    doClear();
    // R1 restart equals first update after reset
    update(1234, 1'b1, -777, 1'b1, "R1 restart");

    doClear();
    // R5 pure phase loop with a large disabled frequency value
    for (int k = 0; k < 15; k++) update(30000, 1'b0, 600 - 80 * k, 1'b1, "R5 gated freq");

    // sweep: signed pairs over all enable combinations (R3 R4 R8)
    for (int en = 0; en < 4; en++) begin
      doClear();
      for (int f = -2; f <= 2; f++)
        for (int p = -2; p <= 2; p++)
          update(f * 4001 + 1, en[0], p * 3999 - 1, en[1], "R8 sweep");
    end

    // R7 saturation both directions on the narrow order-2 instance
    doClear();
    gFreqAcc = 16'sd16383;
    gPhaseAcc = 16'sd16383;
    for (int k = 0; k < 30; k++) update(30000, 1'b1, 30000, 1'b1, "R7 high");
    chk("R7 order2 upper limit", longint'(cmd2), 524287);
    for (int k = 0; k < 60; k++) update(-30000, 1'b1, -30000, 1'b1, "R7 low");
    chk("R7 order2 lower limit", longint'(cmd2), -524288);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule